// File: doc/BRIEF.md
# Receive FIFO and Line Status Unit

This unit sits on the receive side of a 16550-class serial port. Each byte that the deserialiser completes is queued together with its own parity, framing and break flags in a receive FIFO. Software pulls bytes out by reading the receive data port. It learns the state of both directions from an eight-bit line status word. Overrun is detected inside the unit: it is the arrival of a byte when no slot is free.

Software can run the receive side, the transmit side, or both without interrupts by clearing the matching enable bits. With every enable clear and the FIFO on, the port is fully polled. The FIFO still stores characters in that mode, but no trigger-level indication is raised. The status word then carries all of the information: per-character error bits for the character at the head, a queue-wide error summary, and the transmitter empty flags.

Top module: `uart_lsr_unit`

## Requirements
- R1: When `ier` is all zero, `irq` and `rx_trig` stay low whatever the FIFO and status contents are, while bytes are still queued and read out normally.
- R2: `lsr[0]` is 1 exactly while the receive FIFO holds at least one byte. After reset `lsr` reads 8'h60 when both transmitter empty inputs are high.
- R3: A byte strobed while the FIFO is full is discarded, the queued contents are kept, and `lsr[1]` (overrun) is set. Full means 16 entries with `fifo_en`=1 and 1 entry with `fifo_en`=0. A pop in the same cycle does not rescue the incoming byte.
- R4: `lsr[2]`, `lsr[3]` and `lsr[4]` show the parity, framing and break flags stored with the entry now at the head of the FIFO. They are 0 when the FIFO is empty.
- R5: A status read (`rd_lsr`) clears `lsr[1]` through `lsr[4]` from the next cycle. The head's error bits stay clear until that entry is popped. An overrun in the same cycle as the read leaves `lsr[1]` set.
- R6: `lsr[5]` equals `thr_empty`, and `lsr[6]` equals `thr_empty` AND `tsr_empty`, both in the same cycle.
- R7: `lsr[7]` is 1 while any queued entry carries a parity, framing or break flag. It falls once the last such entry is popped, and a status read does not clear it.
- R8: `rd_rbr` pops exactly one entry in first-in first-out order. `rbr_data` shows the head byte, or 0 when the FIFO is empty. A pop on an empty FIFO changes nothing.
- R9: `irq` is the OR of three enabled sources. `ier[0]` enables received data: level reached with `fifo_en`=1, any byte with `fifo_en`=0. `ier[1]` enables the holding register being empty. `ier[2]` enables any of `lsr[1]` to `lsr[4]`.
- R10: `rx_trig` is 1 when `fifo_en`=1, `ier[0]`=1 and the FIFO holds at least RX_TRIG (8) entries.
- R11: A strobe, pop or status read takes effect at the clock edge that samples it, and the outputs show the result in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = 16-entry FIFO, 0 = single holding slot |
| ier | input | 3 | Interrupt enables: [0] rx data, [1] tx empty, [2] line status |
| rx_strobe | input | 1 | Received byte complete |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error flag of the byte |
| rx_frm_err | input | 1 | Framing error flag of the byte |
| rx_brk | input | 1 | Break flag of the byte |
| thr_empty | input | 1 | Transmit holding register empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| rd_lsr | input | 1 | Status word read strobe |
| rd_rbr | input | 1 | Receive data read strobe (pop) |
| lsr | output | 8 | Line status word |
| rbr_data | output | 8 | Byte at the FIFO head |
| irq | output | 1 | Interrupt request |
| rx_trig | output | 1 | Receive trigger level reached |

## Verification
Stored state changes at the edge that samples a strobe, pop or status read, so every stored result is due one cycle later. The transmitter bits, `irq` and `rx_trig` follow their inputs in the same cycle. The bench applies each stimulus in the low half of the clock and compares all outputs one nanosecond later against a behavioural queue model. That model is advanced at the following rising edge, so it predicts same-cycle combinational results and next-cycle stored results with no guesswork about ordering. Full-FIFO overrun, a pop together with a push while full, empty pops, single-slot mode and each interrupt source are all driven.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_entry_t;

    localparam int LSR_DR   = 0;
    localparam int LSR_OE   = 1;
    localparam int LSR_PE   = 2;
    localparam int LSR_FE   = 3;
    localparam int LSR_BI   = 4;
    localparam int LSR_THRE = 5;
    localparam int LSR_TEMT = 6;
    localparam int LSR_ERRQ = 7;

    localparam int IE_RX = 0;
    localparam int IE_TX = 1;
    localparam int IE_LS = 2;

    function automatic logic entry_bad(rx_entry_t e);
        return e.brk | e.frm | e.par;
    endfunction

endpackage

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
    import lsr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          single_slot,
    input  logic          push_req,
    input  rx_entry_t     wr_entry,
    input  logic          pop_req,
    output rx_entry_t     head,
    output logic [CW-1:0] count,
    output logic          overflow,
    output logic          push_ok,
    output logic          pop_ok
);
    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   cnt_q;
    logic            full, empty;

    assign empty    = (cnt_q == '0);
    assign full     = single_slot ? !empty : (cnt_q == CW'(DEPTH));
    assign push_ok  = push_req && !full;
    assign overflow = push_req && full;
    assign pop_ok   = pop_req && !empty;
    assign head     = empty ? '0 : mem[rd_ptr];
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/lsr_err_tally.sv
module lsr_err_tally #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic add,
    input  logic sub,
    output logic any_bad
);
    logic [CW-1:0] bad_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_cnt <= '0;
        end else begin
            case ({add, sub})
                2'b10:   bad_cnt <= bad_cnt + 1'b1;
                2'b01:   bad_cnt <= bad_cnt - 1'b1;
                default: bad_cnt <= bad_cnt;
            endcase
        end
    end

    assign any_bad = (bad_cnt != '0);
endmodule

// File: rtl/lsr_status.sv
module lsr_status
    import lsr_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int RX_TRIG = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic [2:0]    ier,
    input  logic          overflow,
    input  logic          rd_lsr,
    input  logic          pop_ok,
    input  rx_entry_t     head,
    input  logic [CW-1:0] count,
    input  logic          any_bad,
    input  logic          thr_empty,
    input  logic          tsr_empty,
    output logic [7:0]    lsr,
    output logic          irq,
    output logic          rx_trig
);
    logic ovr_q;
    logic head_seen_q;
    logic nonempty;
    logic level_hit;
    logic rx_src;

    assign nonempty  = (count != '0);
    assign level_hit = (count >= CW'(RX_TRIG));

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q       <= 1'b0;
            head_seen_q <= 1'b0;
        end else begin
            if (overflow)    ovr_q <= 1'b1;
            else if (rd_lsr) ovr_q <= 1'b0;

            if (pop_ok)                   head_seen_q <= 1'b0;
            else if (rd_lsr && nonempty)  head_seen_q <= 1'b1;
        end
    end

    always_comb begin
        lsr           = '0;
        lsr[LSR_DR]   = nonempty;
        lsr[LSR_OE]   = ovr_q;
        lsr[LSR_PE]   = nonempty && !head_seen_q && head.par;
        lsr[LSR_FE]   = nonempty && !head_seen_q && head.frm;
        lsr[LSR_BI]   = nonempty && !head_seen_q && head.brk;
        lsr[LSR_THRE] = thr_empty;
        lsr[LSR_TEMT] = thr_empty && tsr_empty;
        lsr[LSR_ERRQ] = any_bad;
    end

    assign rx_src  = fifo_en ? level_hit : nonempty;
    assign rx_trig = fifo_en && ier[IE_RX] && level_hit;
    assign irq     = (ier[IE_RX] && rx_src)
                   || (ier[IE_TX] && thr_empty)
                   || (ier[IE_LS] && (|lsr[LSR_BI:LSR_OE]));
endmodule

// File: rtl/uart_lsr_unit.sv
module uart_lsr_unit
    import lsr_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int RX_TRIG = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_en,
    input  logic [2:0] ier,
    input  logic       rx_strobe,
    input  logic [7:0] rx_data,
    input  logic       rx_par_err,
    input  logic       rx_frm_err,
    input  logic       rx_brk,
    input  logic       thr_empty,
    input  logic       tsr_empty,
    input  logic       rd_lsr,
    input  logic       rd_rbr,
    output logic [7:0] lsr,
    output logic [7:0] rbr_data,
    output logic       irq,
    output logic       rx_trig
);
    rx_entry_t     in_entry, head;
    logic [CW-1:0] fifo_cnt;
    logic          overflow, push_ok, pop_ok, any_bad;

    always_comb begin
        in_entry.data = rx_data;
        in_entry.par  = rx_par_err;
        in_entry.frm  = rx_frm_err;
        in_entry.brk  = rx_brk;
    end

    lsr_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .single_slot(!fifo_en),
        .push_req   (rx_strobe),
        .wr_entry   (in_entry),
        .pop_req    (rd_rbr),
        .head       (head),
        .count      (fifo_cnt),
        .overflow   (overflow),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok)
    );

    lsr_err_tally #(.DEPTH(DEPTH)) u_tally (
        .clk    (clk),
        .rst    (rst),
        .add    (push_ok && entry_bad(in_entry)),
        .sub    (pop_ok && entry_bad(head)),
        .any_bad(any_bad)
    );

    lsr_status #(.DEPTH(DEPTH), .RX_TRIG(RX_TRIG)) u_status (
        .clk      (clk),
        .rst      (rst),
        .fifo_en  (fifo_en),
        .ier      (ier),
        .overflow (overflow),
        .rd_lsr   (rd_lsr),
        .pop_ok   (pop_ok),
        .head     (head),
        .count    (fifo_cnt),
        .any_bad  (any_bad),
        .thr_empty(thr_empty),
        .tsr_empty(tsr_empty),
        .lsr      (lsr),
        .irq      (irq),
        .rx_trig  (rx_trig)
    );

    assign rbr_data = head.data;
endmodule

// File: rtl/uart_lsr_unit_chk.sv
module uart_lsr_unit_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    ier,
    input logic          rx_strobe,
    input logic          rd_lsr,
    input logic          rd_rbr,
    input logic [7:0]    lsr,
    input logic          irq,
    input logic          rx_trig,
    input logic [CW-1:0] fifo_count
);
    AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ier == 3'b000) |-> (!irq && !rx_trig)); // R1

    AST_DATA_READY: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && !lsr[0]) |=> lsr[0]); // R2

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(lsr[1]) |-> $past(rx_strobe)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH)); // R3

    AST_READ_CLR_OVR: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !rx_strobe) |=> !lsr[1]); // R5

    AST_READ_CLR_HEAD: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && lsr[0] && !rd_rbr) |=> (lsr[4:2] == 3'b000)); // R5

    AST_SUMMARY_COVERS_HEAD: assert property (@(posedge clk) disable iff (rst)
        (|lsr[4:2]) |-> lsr[7]); // R7

    AST_EMPTY_POP_SAFE: assert property (@(posedge clk) disable iff (rst)
        (rd_rbr && !lsr[0] && !rx_strobe) |=> (!lsr[0] && $stable(fifo_count))); // R8
endmodule

bind uart_lsr_unit uart_lsr_unit_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ier       (ier),
    .rx_strobe (rx_strobe),
    .rd_lsr    (rd_lsr),
    .rd_rbr    (rd_rbr),
    .lsr       (lsr),
    .irq       (irq),
    .rx_trig   (rx_trig),
    .fifo_count(fifo_cnt)
);

// File: tb/uart_lsr_unit_bench.sv
`timescale 1ns/1ps
module uart_lsr_unit_bench;
    localparam int DEPTH = 16;
    localparam int TRIG  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b1;
    logic [2:0] ier = 3'b000;
    logic       rx_strobe = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
    logic       thr_empty = 1'b1, tsr_empty = 1'b1;
    logic       rd_lsr = 1'b0, rd_rbr = 1'b0;
    logic [7:0] lsr, rbr_data;
    logic       irq, rx_trig;

    int checks = 0;
    int errors = 0;

    // model state: entry = {brk, frm, par, data}
    logic [10:0] q[$];
    bit m_ovr  = 1'b0;
    bit m_seen = 1'b0;

    always #2 clk = ~clk;

    uart_lsr_unit u_uart_lsr_unit (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .ier(ier),
        .rx_strobe(rx_strobe), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .thr_empty(thr_empty),
        .tsr_empty(tsr_empty), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
        .lsr(lsr), .rbr_data(rbr_data), .irq(irq), .rx_trig(rx_trig)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [7:0]  e_lsr;
        logic [10:0] hd;
        bit          any_err, lvl, e_irq, e_trig, nonempty;
        nonempty = (q.size() > 0);
        hd = nonempty ? q[0] : 11'd0;
        any_err = 1'b0;
        foreach (q[i]) if (q[i][10:8] != 3'b000) any_err = 1'b1;
        e_lsr = 8'h00;
        e_lsr[0] = nonempty;
        e_lsr[1] = m_ovr;
        e_lsr[4:2] = (nonempty && !m_seen) ? {hd[10], hd[9], hd[8]} : 3'b000;
        e_lsr[5] = thr_empty;
        e_lsr[6] = thr_empty && tsr_empty;
        e_lsr[7] = any_err;
        lvl = (q.size() >= TRIG);
        e_trig = fifo_en && ier[0] && lvl;
        e_irq = (ier[0] && (fifo_en ? lvl : nonempty)) || (ier[1] && thr_empty)
              || (ier[2] && (e_lsr[4:1] != 4'b0000));
        check("R2 data ready", {7'd0, lsr[0]}, {7'd0, e_lsr[0]});
        check("R3 R5 overrun bit", {7'd0, lsr[1]}, {7'd0, e_lsr[1]});
        check("R4 R5 head error bits", {5'd0, lsr[4:2]}, {5'd0, e_lsr[4:2]});
        check("R6 transmitter bits", {6'd0, lsr[6:5]}, {6'd0, e_lsr[6:5]});
        check("R7 queue error summary", {7'd0, lsr[7]}, {7'd0, e_lsr[7]});
        check("R8 R11 head data", rbr_data, hd[7:0]);
        check("R9 irq", {7'd0, irq}, {7'd0, e_irq});
        check("R10 rx_trig", {7'd0, rx_trig}, {7'd0, e_trig});
        if (ier == 3'b000) check("R1 polled quiet", {6'd0, irq, rx_trig}, 8'd0);
    endtask

    task automatic model_edge();
        bit full, pop;
        if (rst) begin
            q.delete(); m_ovr = 1'b0; m_seen = 1'b0;
            return;
        end
        full = fifo_en ? (q.size() == DEPTH) : (q.size() != 0);
        pop  = rd_rbr && (q.size() > 0);
        if (rx_strobe && full) m_ovr = 1'b1;
        else if (rd_lsr) m_ovr = 1'b0;
        if (pop) m_seen = 1'b0;
        else if (rd_lsr && q.size() > 0) m_seen = 1'b1;
        if (pop) void'(q.pop_front());
        if (rx_strobe && !full) q.push_back({rx_brk, rx_frm_err, rx_par_err, rx_data});
    endtask

    task automatic cyc(input bit s, input logic [7:0] d, input logic [2:0] fl,
                       input bit rl, input bit rr);
        @(negedge clk);
        rx_strobe = s; rx_data = d;
        rx_par_err = fl[0]; rx_frm_err = fl[1]; rx_brk = fl[2];
        rd_lsr = rl; rd_rbr = rr;
        #1;
        if (!rst) compare_all();
        @(posedge clk);
        model_edge();
    endtask

    initial begin
        int wd = 0;
        while (wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc(0, 8'h00, 3'b000, 0, 0);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R2 reset status", lsr, 8'h60);
        check("R8 reset data", rbr_data, 8'h00);
        // queue three characters with distinct flags (polled, R1)
        cyc(1, 8'hA5, 3'b000, 0, 0);
        cyc(1, 8'h3C, 3'b001, 0, 0);
        cyc(1, 8'h81, 3'b110, 0, 0);
        cyc(0, 8'h00, 3'b000, 0, 0);
        cyc(0, 8'h00, 3'b000, 0, 1);   // pop clean A5, head now parity
        cyc(0, 8'h00, 3'b000, 1, 0);   // status read clears head bits (R5)
        cyc(0, 8'h00, 3'b000, 0, 0);
        cyc(0, 8'h00, 3'b000, 0, 1);
        cyc(0, 8'h00, 3'b000, 0, 1);
        cyc(0, 8'h00, 3'b000, 0, 1);   // pop on empty
        cyc(0, 8'h00, 3'b000, 0, 0);
        // fill beyond capacity
        for (int i = 0; i < DEPTH + 2; i++)
            cyc(1, 8'(8'h10 + i), (i == 5) ? 3'b010 : 3'b000, 0, 0);
        cyc(1, 8'hEE, 3'b000, 0, 1);   // push with pop while full: byte lost
        cyc(1, 8'hDD, 3'b000, 1, 0);   // read with overrun same cycle
        cyc(0, 8'h00, 3'b000, 1, 0);
        cyc(0, 8'h00, 3'b000, 0, 0);
        // interrupt sources
        ier = 3'b001; cyc(0, 8'h00, 3'b000, 0, 0);
        ier = 3'b010; thr_empty = 1'b0; cyc(0, 8'h00, 3'b000, 0, 0);
        thr_empty = 1'b1; tsr_empty = 1'b0; cyc(0, 8'h00, 3'b000, 0, 0);
        ier = 3'b100; cyc(1, 8'h55, 3'b000, 0, 0);
        cyc(0, 8'h00, 3'b000, 0, 0);
        cyc(0, 8'h00, 3'b000, 1, 0);
        ier = 3'b001;
        for (int i = 0; i < DEPTH; i++) cyc(0, 8'h00, 3'b000, 0, 1);
        for (int i = 0; i < TRIG; i++) cyc(1, 8'(8'h40 + i), 3'b000, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 3'b000, 0, 1);
        // single-slot mode
        fifo_en = 1'b0; ier = 3'b000;
        for (int i = 0; i < TRIG; i++) cyc(0, 8'h00, 3'b000, 0, 1);
        cyc(1, 8'h77, 3'b100, 0, 0);
        ier = 3'b101;
        cyc(1, 8'h66, 3'b000, 0, 0);
        cyc(0, 8'h00, 3'b000, 0, 0);
        cyc(0, 8'h00, 3'b000, 1, 1);
        thr_empty = 1'b0; tsr_empty = 1'b1; ier = 3'b000;
        cyc(0, 8'h00, 3'b000, 0, 0);
        cyc(0, 8'h00, 3'b000, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule